// File: doc/BRIEF.md
# DDR Deserializer Bitslip Pulse Controller

This block sets the word alignment of one incoming DQ group on a double-data-rate input deserializer. A training engine asks for a shift of 0 to 7 bit positions. Shift 0 keeps the deserializer at its largest latency. Each further effective shift picks newer sampled data.

In DDR mode, successive bitslip pulses alternate in their effect on the pattern: one shifts it right by one position and the next shifts it left by three. The pulse count therefore does not follow the shift. The block turns the shift into the matching pulse count. Because pulse effects add up, the block first resets the deserializer to its zero-shift alignment. It then waits for the deserializer to settle and issues the pulses one clock wide with fixed idle spacing. A one-cycle done flag ends each operation.

Requests use a valid/ready handshake. Only one request is in progress at a time.

Top module: `slip_pulse_ctrl`

## Requirements
- R1: While `rst_n` is low, `deser_rst`, `slip_pulse`, `slip_done` and `req_ready` are all low. After `rst_n` rises, `req_ready` goes high by the second rising clock edge.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when no operation is in progress. A request presented while `req_ready` is low has no effect on the alignment that results.
- R3: In the cycle after a request is accepted, `deser_rst` goes high. It stays high for exactly 2 cycles.
- R4: The shift value on `req_shift` (unsigned, 3 bits) sets the pulse count: shifts 0,1,2,3,4,5,6,7 give 0,3,2,5,4,7,6,1 pulses.
- R5: Each `slip_pulse` lasts exactly one cycle. Consecutive pulses of one operation have exactly 2 idle cycles between them.
- R6: No pulse occurs while `deser_rst` is high. The first pulse follows exactly 4 cycles in which `deser_rst` is low.
- R7: `slip_done` is high for exactly one cycle. That cycle comes right after the last pulse, or right after the 4 settle cycles when the pulse count is zero. `req_ready` is high in the following cycle.
- R8: Consider a deserializer model that clears its alignment to 0 on `deser_rst`. It moves its alignment by -1 (mod 8) on the 1st, 3rd, 5th... pulse and by +3 (mod 8) on the 2nd, 4th, 6th... pulse. In that model, the alignment when `slip_done` is high equals the accepted shift.
- R9: Count the cycles from the acceptance edge up to and including the `slip_done` cycle. The count is 7 for zero pulses and 3*P+5 for P pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Shift request present |
| req_shift | input | 3 | Requested alignment shift, 0 to 7 |
| req_ready | output | 1 | Block idle and able to take a request |
| deser_rst | output | 1 | Reset to the deserializer alignment logic |
| slip_pulse | output | 1 | One-cycle bitslip pulse to the deserializer |
| slip_done | output | 1 | One-cycle flag after the last pulse |

## Verification
The hardest situation to reach is a request that arrives while an operation is already running. It tests whether a stray handshake can disturb a sequence in progress. The stimulus holds `req_valid` high with a different shift during the reset and settle phases of a long seven-pulse operation. The bench releases it before the block returns to idle. A reference model of the alternating rule then shows that the final alignment still matches the first request.

A second hard case is reset asserted in the middle of a pulse train. After release, the next operation must still start from alignment zero.

// File: rtl/slip_ctrl_pkg.sv
package slip_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_RESET  = 3'd1,
    SEQ_SETTLE = 3'd2,
    SEQ_PULSE  = 3'd3,
    SEQ_GAP    = 3'd4,
    SEQ_DONE   = 3'd5
  } seq_state_e;

  // Walk the alternating slip rule (first pulse -1, next +3, repeating,
  // modulo 2**width) and return the first pulse count reaching 'shift'.
  function automatic int unsigned pulses_for_shift(input int unsigned shift,
                                                   input int unsigned width);
    int unsigned span;
    int unsigned pos;
    int unsigned found_at;
    logic        found;
    span     = 1 << width;
    pos      = 0;
    found_at = 0;
    found    = 1'b0;
    for (int unsigned k = 0; k < span; k++) begin
      if (!found && pos == shift) begin
        found    = 1'b1;
        found_at = k;
      end
      if (k[0] == 1'b0) pos = (pos + span - 1) % span;
      else              pos = (pos + 3) % span;
    end
    return found_at;
  endfunction

endpackage

// File: rtl/slip_rst_sync.sv
module slip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/slip_count_map.sv
module slip_count_map
  import slip_ctrl_pkg::*;
#(
  parameter int unsigned SHIFT_W = 3
) (
  input  logic [SHIFT_W-1:0] shift,
  output logic [SHIFT_W-1:0] pulses
);
  localparam int unsigned N_SHIFT = 1 << SHIFT_W;

  logic [SHIFT_W-1:0] lut [N_SHIFT];

  generate
    for (genvar s = 0; s < N_SHIFT; s++) begin : g_lut
      assign lut[s] = SHIFT_W'(pulses_for_shift(s, SHIFT_W));
    end
  endgenerate

  assign pulses = lut[shift];
endmodule

// File: rtl/slip_wait_timer.sv
module slip_wait_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/slip_seq_fsm.sv
module slip_seq_fsm
  import slip_ctrl_pkg::*;
#(
  parameter int unsigned SHIFT_W       = 3,
  parameter int unsigned RST_CYCLES    = 2,
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned GAP_CYCLES    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SHIFT_W-1:0] pulse_cnt,
  output logic               idle,
  output logic               deser_rst,
  output logic               slip_pulse,
  output logic               slip_done
);
  localparam int unsigned WAIT_A   = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int unsigned WAIT_MAX = (WAIT_A > GAP_CYCLES) ? WAIT_A : GAP_CYCLES;
  localparam int unsigned CNT_W    = (WAIT_MAX < 2) ? 1 : $clog2(WAIT_MAX);
  localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD    = CNT_W'(GAP_CYCLES - 1);

  seq_state_e         state_q, state_d;
  logic [SHIFT_W-1:0] rem_q, rem_d;
  logic               rem_en;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               idle_q, deser_rst_q, slip_pulse_q, slip_done_q;

  slip_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    rem_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d  = SEQ_RESET;
          rem_d    = pulse_cnt;
          rem_en   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = RST_LOAD;
        end
      end
      SEQ_RESET: begin
        if (tmr_zero) begin
          state_d  = SEQ_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LOAD;
        end
      end
      SEQ_SETTLE: begin
        if (tmr_zero) state_d = (rem_q == '0) ? SEQ_DONE : SEQ_PULSE;
      end
      SEQ_PULSE: begin
        rem_d  = rem_q - 1'b1;
        rem_en = 1'b1;
        if (rem_q == SHIFT_W'(1)) begin
          state_d = SEQ_DONE;
        end else begin
          state_d  = SEQ_GAP;
          tmr_load = 1'b1;
          tmr_val  = GAP_LOAD;
        end
      end
      SEQ_GAP: begin
        if (tmr_zero) state_d = SEQ_PULSE;
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  // State and output registers; outputs decoded from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      idle_q       <= 1'b1;
      deser_rst_q  <= 1'b0;
      slip_pulse_q <= 1'b0;
      slip_done_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      idle_q       <= (state_d == SEQ_IDLE);
      deser_rst_q  <= (state_d == SEQ_RESET);
      slip_pulse_q <= (state_d == SEQ_PULSE);
      slip_done_q  <= (state_d == SEQ_DONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign idle       = idle_q;
  assign deser_rst  = deser_rst_q;
  assign slip_pulse = slip_pulse_q;
  assign slip_done  = slip_done_q;
endmodule

// File: rtl/slip_pulse_ctrl.sv
module slip_pulse_ctrl
  import slip_ctrl_pkg::*;
#(
  parameter int unsigned SHIFT_W       = 3,
  parameter int unsigned RST_CYCLES    = 2,
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned GAP_CYCLES    = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [SHIFT_W-1:0] req_shift,
  output logic               req_ready,
  output logic               deser_rst,
  output logic               slip_pulse,
  output logic               slip_done
);
  logic               rst_n_sync;
  logic               fsm_idle;
  logic               accept;
  logic [SHIFT_W-1:0] pulse_cnt;

  slip_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  slip_count_map #(.SHIFT_W(SHIFT_W)) u_map (
    .shift  (req_shift),
    .pulses (pulse_cnt)
  );

  assign req_ready = fsm_idle & rst_n_sync;
  assign accept    = req_valid & req_ready;

  slip_seq_fsm #(
    .SHIFT_W       (SHIFT_W),
    .RST_CYCLES    (RST_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (accept),
    .pulse_cnt  (pulse_cnt),
    .idle       (fsm_idle),
    .deser_rst  (deser_rst),
    .slip_pulse (slip_pulse),
    .slip_done  (slip_done)
  );
endmodule

// File: rtl/slip_pulse_ctrl_chk.sv
module slip_pulse_ctrl_chk #(
  parameter int unsigned SHIFT_W       = 3,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic deser_rst,
  input logic slip_pulse,
  input logic slip_done
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYCLES);
  localparam logic [SHIFT_W:0] PULSE_LIMIT = (SHIFT_W+1)'((1 << SHIFT_W) - 1);

  logic [SW-1:0]    since_rst_q;
  logic [SHIFT_W:0] pulses_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_rst_q <= '0;
    else if (deser_rst)               since_rst_q <= '0;
    else if (since_rst_q < SETTLE_V)  since_rst_q <= since_rst_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pulses_q <= '0;
    else if (deser_rst)  pulses_q <= '0;
    else if (slip_pulse) pulses_q <= pulses_q + 1'b1;
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!deser_rst && !slip_pulse && !slip_done));

  assert_accept_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> deser_rst);

  assert_pulse_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> (pulses_q < PULSE_LIMIT));

  assert_slip_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse ##1 !slip_pulse);

  assert_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> (!deser_rst && since_rst_q >= SETTLE_V));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slip_done |=> (!slip_done && req_ready));
endmodule

bind slip_pulse_ctrl slip_pulse_ctrl_chk #(
  .SHIFT_W       (SHIFT_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .deser_rst  (deser_rst),
  .slip_pulse (slip_pulse),
  .slip_done  (slip_done)
);

// File: tb/slip_pulse_ctrl_bench.sv
module slip_pulse_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_shift;
  logic       req_ready;
  logic       deser_rst;
  logic       slip_pulse;
  logic       slip_done;

  int total;
  int bad;

  // reference deserializer model and timing monitor
  int pos, npulse, rst_len, rst_len_last, since_rst, first_lat, since_pulse, spacing_bad;

  slip_pulse_ctrl u_slip_pulse_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_shift  (req_shift),
    .req_ready  (req_ready),
    .deser_rst  (deser_rst),
    .slip_pulse (slip_pulse),
    .slip_done  (slip_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expected_pulses(input int s);
    case (s)
      0: return 0; 1: return 3; 2: return 2; 3: return 5;
      4: return 4; 5: return 7; 6: return 6; default: return 1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      pos = 0; npulse = 0; rst_len = 0; rst_len_last = 0;
      since_rst = 0; first_lat = -1; since_pulse = 0; spacing_bad = 0;
    end else begin
      if (deser_rst) begin
        pos = 0; npulse = 0; rst_len = rst_len + 1; since_rst = 0;
        first_lat = -1; spacing_bad = 0;
      end else begin
        if (rst_len != 0) rst_len_last = rst_len;
        rst_len = 0;
        since_rst = since_rst + 1;
      end
      if (slip_pulse) begin
        npulse = npulse + 1;
        if (npulse % 2 == 1) pos = (pos + 7) % 8;
        else                 pos = (pos + 3) % 8;
        if (npulse == 1) first_lat = since_rst;
        else if (since_pulse != 2) spacing_bad = spacing_bad + 1;
        since_pulse = 0;
      end else begin
        since_pulse = since_pulse + 1;
      end
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic wait_ready;
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
  endtask

  // One full request; optionally present a second request while busy (R2)
  task automatic run_shift(input int s, input bit inject_busy);
    int lat;
    int p;
    p = expected_pulses(s);
    wait_ready();
    req_valid = 1'b1;
    req_shift = 3'(s);
    @(posedge clk);
    @(negedge clk);
    lat = 1;
    if (inject_busy) begin
      req_shift = 3'(s ^ 3);
      check_eq("R2", "ready while busy", int'(req_ready), 0);
      @(negedge clk); lat++;
      @(negedge clk); lat++;
      check_eq("R2", "ready while busy later", int'(req_ready), 0);
      req_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
    end
    while (!slip_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check_eq("R9", $sformatf("latency shift %0d", s), lat, (p == 0) ? 7 : 3*p + 5);
    check_eq("R4", $sformatf("pulse count shift %0d", s), npulse, p);
    check_eq("R8", $sformatf("alignment shift %0d", s), pos, s);
    check_eq("R3", $sformatf("deser_rst width shift %0d", s), rst_len_last, 2);
    check_eq("R5", $sformatf("spacing shift %0d", s), spacing_bad, 0);
    if (p > 0) check_eq("R6", $sformatf("settle shift %0d", s), first_lat, 5);
    @(negedge clk);
    check_eq("R7", "done width", int'(slip_done), 0);
    check_eq("R7", "ready after done", int'(req_ready), 1);
  endtask

  task automatic test_reset_state;
    check_eq("R1", "pulse in reset", int'(slip_pulse), 0);
    check_eq("R1", "deser_rst in reset", int'(deser_rst), 0);
    check_eq("R1", "done in reset", int'(slip_done), 0);
    check_eq("R1", "ready in reset", int'(req_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check_eq("R1", "ready after release", int'(req_ready), 1);
  endtask

  task automatic test_all_shifts;
    int order [8] = '{3, 0, 7, 1, 6, 2, 5, 4};
    foreach (order[i]) run_shift(order[i], 1'b0);
  endtask

  task automatic test_busy_ignore;
    run_shift(5, 1'b1);
  endtask

  task automatic test_mid_reset;
    wait_ready();
    req_valid = 1'b1;
    req_shift = 3'd5;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 9; i++) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R1", "pulse during mid reset", int'(slip_pulse), 0);
    check_eq("R1", "ready during mid reset", int'(req_ready), 0);
    check_eq("R1", "deser_rst during mid reset", int'(deser_rst), 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check_eq("R1", "ready after mid reset", int'(req_ready), 1);
    run_shift(6, 1'b0);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_shift = 3'd0;
    repeat (3) @(negedge clk);
    test_reset_state();
    test_all_shifts();
    test_busy_ignore();
    test_mid_reset();
    repeat (3) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL R8 watchdog expired: got 0 expected 1");
    report();
    $finish;
  end
endmodule